// File: doc/BRIEF.md
# Synchronous FIFO with Loadable Threshold Offsets

This block is a single-clock, 9-bit-wide first-in first-out buffer of parameterised depth. It reports four active-low status flags: full, empty, nearly-empty and nearly-full. The nearly-empty and nearly-full thresholds are not fixed. They are held in four byte registers that software writes and reads back through the same data ports that carry FIFO traffic.

One input pin has two roles. Its level while reset is held chooses the role, and that choice lasts until the next reset. If the pin is high during reset, the block enters state `MODE_WEN2`, where the pin is a second, active-high write enable. If the pin is low during reset, the block enters state `MODE_LOAD`, where the pin is an active-low load strobe. In `MODE_LOAD`, a strobed write stores `wdata[7:0]` into the selected offset byte. A strobed read places the selected byte on the read port. Neither strobed access touches FIFO contents.

A four-state byte selector walks through `SEL_AE_LO`, `SEL_AE_HI`, `SEL_AF_LO` and `SEL_AF_HI` on every strobed access. After `SEL_AF_HI` it returns to `SEL_AE_LO`. An output enable places the read port in high impedance.

Top module: `offset_flag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the FIFO is emptied. After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1 and the read register holds 0. Both thresholds become 7 (low byte 7, high byte 0), and the byte selector returns to `SEL_AE_LO`.
- R2: Words are read back in the order written, with all 9 bits intact. A read loads the oldest word into the read register at the clock edge of the read.
- R3: A word is pushed only when `wr_en1_n`=0 and `wr_en2_ld`=1. This applies in both modes.
- R4: A word is popped only when both `rd_en1_n`=0 and `rd_en2_n`=0. If either is high, the read register holds its value.
- R5: A write while full and a read while empty are ignored. FIFO contents, flags and the read register are unchanged by the ignored access.
- R6: `full_n` is 0 exactly when DEPTH words are stored. `empty_n` is 0 exactly when no word is stored.
- R7: `aempty_n` is 0 exactly when the stored count is at or below the nearly-empty threshold. `afull_n` is 0 exactly when DEPTH minus the count is at or below the nearly-full threshold. Each threshold equals high byte × 256 + low byte.
- R8: In `MODE_LOAD`, a clock edge with `wr_en2_ld`=0 and `wr_en1_n`=0 stores `wdata[7:0]` into the selected byte. `wdata[8]` is ignored, and no word is pushed. The selection order is: nearly-empty low, nearly-empty high, nearly-full low, nearly-full high.
- R9: In `MODE_LOAD`, a clock edge with `wr_en2_ld`=0 and both read enables low loads {0, selected byte} into the read register and pops nothing. If a strobed write happens at the same edge, the value loaded is the byte as it was before that write.
- R10: Each clock edge with a strobed write, a strobed read, or both advances the byte selector by exactly one position. After the fourth position it wraps to the first.
- R11: The role of `wr_en2_ld` is sampled while `rst_n` is low and held after reset. In `MODE_WEN2`, no offset access exists, and a low `wr_en2_ld` only blocks writes.
- R12: When `oe_n`=1, `rdata` is high impedance. When `oe_n`=0, `rdata` drives the read register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Second write enable (high) or load strobe (low), role fixed at reset |
| wdata | input | 9 | Write data; bits 7:0 carry offset bytes |
| rd_en1_n | input | 1 | Active-low read enable 1 |
| rd_en2_n | input | 1 | Active-low read enable 2 |
| oe_n | input | 1 | Active-low output enable for `rdata` |
| rdata | output | 9 | Registered read data, high-Z when disabled |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| afull_n | output | 1 | Low when free space is at or below the nearly-full threshold |
| aempty_n | output | 1 | Low when the count is at or below the nearly-empty threshold |

## Verification
The assertions check several properties on every cycle:
- the stored count never exceeds DEPTH;
- a blocked push or pop leaves the pointers still;
- the byte selector moves on every strobed access and only then;
- a low full or empty flag always brings the matching nearly-flag low with it.

Only the bench scenarios can show the rest: the data ordering, the exact threshold arithmetic after byte loads, the read-back of offset bytes in wrap order, and the reset-latched choice between the two pin roles. These depend on values carried across many cycles and across resets.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;
    localparam int DATA_W      = 9;
    localparam int BYTE_W      = 8;
    localparam int OFS_W       = 2 * BYTE_W;
    localparam int DEFAULT_OFS = 7;

    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } ofs_sel_e;

    typedef enum logic {
        MODE_WEN2 = 1'b0,
        MODE_LOAD = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/ofifo_mode_ctl.sv
module ofifo_mode_ctl
    import ofifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en1_n,
    input  logic wr_en2_ld,
    input  logic rd_en1_n,
    input  logic rd_en2_n,
    output logic push_req,
    output logic pop_req,
    output logic ld_wr,
    output logic ld_rd
);
    pin_mode_e mode_q;
    logic      rd_both;
    logic      strobe;

    // State register: the pin role is captured on every reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= wr_en2_ld ? MODE_WEN2 : MODE_LOAD;
        end
    end

    assign rd_both = !rd_en1_n && !rd_en2_n;

    always_comb begin
        strobe   = 1'b0;
        push_req = 1'b0;
        pop_req  = 1'b0;
        ld_wr    = 1'b0;
        ld_rd    = 1'b0;
        unique case (mode_q)
            MODE_WEN2: begin
                push_req = !wr_en1_n && wr_en2_ld;
                pop_req  = rd_both;
            end
            MODE_LOAD: begin
                strobe   = !wr_en2_ld;
                push_req = !wr_en1_n && !strobe;
                pop_req  = rd_both && !strobe;
                ld_wr    = strobe && !wr_en1_n;
                ld_rd    = strobe && rd_both;
            end
            default: ;
        endcase
    end

    // R8
    ld_excl_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |-> !push_req);
endmodule

// File: rtl/ofifo_offset_regs.sv
module ofifo_offset_regs
    import ofifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_wr,
    input  logic              ld_rd,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] sel_byte,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs
);
    ofs_sel_e          sel_q;
    ofs_sel_e          sel_nxt;
    logic [BYTE_W-1:0] bytes_q [4];
    logic              access;

    assign access = ld_wr || ld_rd;

    always_comb begin
        sel_nxt = sel_q;
        if (access) begin
            unique case (sel_q)
                SEL_AE_LO: sel_nxt = SEL_AE_HI;
                SEL_AE_HI: sel_nxt = SEL_AF_LO;
                SEL_AF_LO: sel_nxt = SEL_AF_HI;
                SEL_AF_HI: sel_nxt = SEL_AE_LO;
                default:   sel_nxt = SEL_AE_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_AE_LO;
        end else begin
            sel_q <= sel_nxt;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_byte
        localparam logic [BYTE_W-1:0] RST_V =
            (g % 2 == 0) ? BYTE_W'(DEFAULT_OFS) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= RST_V;
            end else if (ld_wr && sel_q == ofs_sel_e'(g)) begin
                bytes_q[g] <= wbyte;
            end
        end
    end

    assign sel_byte = bytes_q[sel_q];
    assign ae_ofs   = {bytes_q[SEL_AE_HI], bytes_q[SEL_AE_LO]};
    assign af_ofs   = {bytes_q[SEL_AF_HI], bytes_q[SEL_AF_LO]};

    // R10
    sel_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> sel_q != $past(sel_q));
    // R10
    sel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(sel_q));
endmodule

// File: rtl/ofifo_store.sv
module ofifo_store
    import ofifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              ld_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTE_W-1:0] sel_byte,
    output logic [DATA_W-1:0] rd_q,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic              push_do;
    logic              pop_do;

    assign push_do = push_req && (count != FULL_CNT);
    assign pop_do  = pop_req  && (count != '0);

    always_ff @(posedge clk) begin
        if (push_do) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            rd_q  <= '0;
        end else begin
            if (push_do) wptr <= wptr + 1'b1;
            if (pop_do)  rptr <= rptr + 1'b1;
            unique case ({push_do, pop_do})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (pop_do) begin
                rd_q <= mem[rptr];
            end else if (ld_rd) begin
                rd_q <= {1'b0, sel_byte};
            end
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req) |=> $stable(rptr));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push_req && !pop_req) |=> ($stable(wptr) && count == FULL_CNT));
endmodule

// File: rtl/ofifo_flags.sv
module ofifo_flags
    import ofifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] count,
    input  logic [OFS_W-1:0]       ae_ofs,
    input  logic [OFS_W-1:0]       af_ofs,
    output logic                   full_n,
    output logic                   empty_n,
    output logic                   afull_n,
    output logic                   aempty_n
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] free_cnt;

    assign free_cnt = FULL_CNT - count;
    assign full_n   = !(count == FULL_CNT);
    assign empty_n  = !(count == '0);
    assign aempty_n = !(32'(count)    <= 32'(ae_ofs));
    assign afull_n  = !(32'(free_cnt) <= 32'(af_ofs));

    // R7
    afull_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);
    // R7
    aempty_with_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

// File: rtl/offset_flag_fifo.sv
module offset_flag_fifo
    import ofifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              full_n,
    output logic              empty_n,
    output logic              afull_n,
    output logic              aempty_n
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              push_req;
    logic              pop_req;
    logic              ld_wr;
    logic              ld_rd;
    logic [BYTE_W-1:0] sel_byte;
    logic [OFS_W-1:0]  ae_ofs;
    logic [OFS_W-1:0]  af_ofs;
    logic [DATA_W-1:0] rd_q;
    logic [CW-1:0]     count;

    ofifo_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en1_n  (wr_en1_n),
        .wr_en2_ld (wr_en2_ld),
        .rd_en1_n  (rd_en1_n),
        .rd_en2_n  (rd_en2_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .ld_wr     (ld_wr),
        .ld_rd     (ld_rd)
    );

    ofifo_offset_regs u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_wr    (ld_wr),
        .ld_rd    (ld_rd),
        .wbyte    (wdata[BYTE_W-1:0]),
        .sel_byte (sel_byte),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs)
    );

    ofifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .ld_rd    (ld_rd),
        .wdata    (wdata),
        .sel_byte (sel_byte),
        .rd_q     (rd_q),
        .count    (count)
    );

    ofifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .afull_n  (afull_n),
        .aempty_n (aempty_n)
    );

    assign rdata = oe_n ? {DATA_W{1'bz}} : rd_q;
endmodule

// File: tb/tb_offset_flag_fifo.sv
module tb_offset_flag_fifo;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en1_n = 1'b1;
    logic       wr_en2_ld = 1'b1;
    logic [8:0] wdata = '0;
    logic       rd_en1_n = 1'b1;
    logic       rd_en2_n = 1'b1;
    logic       oe_n = 1'b0;
    wire  [8:0] rdata;
    wire        full_n, empty_n, afull_n, aempty_n;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    int   q[$];
    int   obyte[4];
    int   sel;
    int   exp_rd;
    bit   ld_mode;

    always #2 clk = ~clk;

    offset_flag_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .wdata(wdata), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
        .rdata(rdata), .full_n(full_n), .empty_n(empty_n),
        .afull_n(afull_n), .aempty_n(aempty_n)
    );

    function automatic int ae_thr();
        return obyte[1] * 256 + obyte[0];
    endfunction
    function automatic int af_thr();
        return obyte[3] * 256 + obyte[2];
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        int n = q.size();
        check({req, "/R6 empty_n"}, {8'd0, empty_n}, {8'd0, n != 0});
        check({req, "/R6 full_n"},  {8'd0, full_n},  {8'd0, n != DEPTH});
        check({req, "/R7 aempty_n"}, {8'd0, aempty_n}, {8'd0, !(n <= ae_thr())});
        check({req, "/R7 afull_n"},  {8'd0, afull_n},  {8'd0, !((DEPTH - n) <= af_thr())});
        if (!oe_n) check({req, "/R2 rdata"}, rdata, 9'(exp_rd));
        else       check({req, "/R12 rdata hiz"}, rdata, 9'bz_zzzz_zzzz);
    endtask

    task automatic cycle(string req, bit w1n, bit w2, bit r1n, bit r2n, logic [8:0] d);
        bit strobe, push, rdb, pop, lw, lr, dpush, dpop;
        wr_en1_n = w1n; wr_en2_ld = w2; rd_en1_n = r1n; rd_en2_n = r2n; wdata = d;
        strobe = ld_mode && !w2;
        push   = !w1n && w2;
        rdb    = !r1n && !r2n;
        pop    = rdb && !strobe;
        lw     = strobe && !w1n;
        lr     = strobe && rdb;
        dpush  = push && (q.size() != DEPTH);
        dpop   = pop && (q.size() != 0);
        @(posedge clk);
        if (dpop) exp_rd = q.pop_front();
        if (dpush) q.push_back(int'(d));
        if (lr) exp_rd = obyte[sel];
        if (lw) obyte[sel] = int'(d[7:0]);
        if (lw || lr) sel = (sel + 1) % 4;
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset(bit pin);
        rst_n = 1'b0; wr_en2_ld = pin; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wr_en2_ld = 1'b1;
        q.delete();
        obyte = '{7, 0, 7, 0};
        sel = 0; exp_rd = 0; ld_mode = !pin;
        check_all("R1 reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // Second-write-enable role
        do_reset(1'b1);
        cycle("R11 pin low blocks write", 1'b0, 1'b0, 1'b1, 1'b1, 9'h1AA);
        cycle("R5 read when empty", 1'b1, 1'b1, 1'b0, 1'b0, 9'h0);
        for (int i = 0; i < 3; i++)
            cycle("R3 write", 1'b0, 1'b1, 1'b1, 1'b1, 9'(9'h100 + i));
        cycle("R4 only enable 1", 1'b1, 1'b1, 1'b0, 1'b1, 9'h0);
        cycle("R4 only enable 2", 1'b1, 1'b1, 1'b1, 1'b0, 9'h0);
        for (int i = 0; i < 3; i++)
            cycle("R2 order", 1'b1, 1'b1, 1'b0, 1'b0, 9'h0);
        // Fill to full, overflow, drain
        for (int i = 0; i < DEPTH; i++)
            cycle("R6 fill", 1'b0, 1'b1, 1'b1, 1'b1, 9'($urandom));
        cycle("R5 write when full", 1'b0, 1'b1, 1'b1, 1'b1, 9'h055);
        oe_n = 1'b1;
        cycle("R12 disabled", 1'b1, 1'b1, 1'b0, 1'b0, 9'h0);
        oe_n = 1'b0;
        for (int i = 1; i < DEPTH; i++)
            cycle("R2 drain", 1'b1, 1'b1, 1'b0, 1'b0, 9'h0);
        // Load-strobe role
        do_reset(1'b0);
        for (int i = 0; i < 4; i++)
            cycle("R9 R1 default read", 1'b1, 1'b0, 1'b0, 1'b0, 9'h0);
        cycle("R8 ae lo", 1'b0, 1'b0, 1'b1, 1'b1, 9'h110);
        cycle("R8 ae hi", 1'b0, 1'b0, 1'b1, 1'b1, 9'h100);
        cycle("R8 af lo", 1'b0, 1'b0, 1'b1, 1'b1, 9'h005);
        cycle("R8 af hi", 1'b0, 1'b0, 1'b1, 1'b1, 9'h000);
        for (int i = 0; i < 5; i++)
            cycle("R10 wrap read", 1'b1, 1'b0, 1'b0, 1'b0, 9'h0);
        cycle("R9 read and write", 1'b0, 1'b0, 1'b0, 1'b0, 9'h0FF);
        for (int i = 0; i < 20; i++)
            cycle("R7 thresholds", 1'b0, 1'b1, 1'b1, 1'b1, 9'($urandom));
        // Random mix in load-strobe role
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            bit w2 = (r >= 8);
            cycle("R2 random", ($urandom % 100) >= 55, w2,
                  ($urandom % 100) >= 50, ($urandom % 100) >= 70, 9'($urandom));
            if (i % 400 == 0) oe_n = 1'b1; else oe_n = 1'b0;
        end
        // Random mix in second-enable role
        do_reset(1'b1);
        for (int i = 0; i < 2000; i++)
            cycle("R11 random", ($urandom % 100) >= 40, ($urandom % 100) >= 15,
                  ($urandom % 100) >= 55, ($urandom % 100) >= 20, 9'($urandom));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule